// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block translates 32-bit virtual addresses into physical addresses for a processor pipeline. It holds a set of page translations. Every lookup compares all entries at the same time. Each entry is tagged with an address-space identifier, so translations that belong to different processes can stay resident together. A context switch then only needs a new identifier and no flush. The top three address bits pick a segment. Two kernel segments map straight through to physical memory, one cached and one uncached, and never consult the entries. The user segment and the kernel virtual segment are translated through the entries.

A lookup is combinational. In the same cycle it returns a physical address and an uncached flag, or exactly one exception: address error, miss, or modify fault. A miss is left to a software handler, which refills an entry through the maintenance port. That port selects an entry by index and can write it, clear one entry, or clear all entries. Page table walks and caches sit outside this block.

Top module: `tlb_xlate`

## Requirements
- R1: After a synchronous active-low reset, no entry is valid, so every lookup in a translated segment reports a miss.
- R2: A lookup in a translated segment (address bits 31:29 equal to 0xx or 11x) hits when a valid entry holds the same 20-bit page number (address bits 31:12) and the same identifier. It then returns the entry's physical page above address bits 11:0, with the uncached flag taken from the entry, in the same cycle.
- R3: An entry whose identifier differs from the current one never hits, even when its page number matches.
- R4: Address bits 31:29 equal to 100 or 101 bypass the entries. The physical address is then the virtual address with bits 31:29 cleared, and the uncached flag is 0 for 100 and 1 for 101.
- R5: Kernel-mode accesses with address bits 31:29 equal to 11x are translated through the entries like user addresses.
- R6: A user-mode access with address bit 31 set raises only the address error, whatever the entries hold.
- R7: A store that hits an entry whose write-enable bit is clear, or whose read-only bit is set, raises a modify fault. A load that hits the same entry translates normally.
- R8: When several entries match, the lowest-numbered one supplies the translation.
- R9: Maintenance opcode 01 writes the indexed entry. The new contents are used from the next cycle on, and a lookup in the cycle of the write still sees the old contents.
- R10: Maintenance opcode 10 clears the valid bit of only the indexed entry.
- R11: Maintenance opcode 11 clears every valid bit in a single cycle. Opcode 00 does nothing.
- R12: At most one exception output is high, and all of them are low when no lookup is requested. An excepting lookup drives physical address 0 and uncached 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address |
| lk_asid | input | 6 | Current address-space identifier |
| lk_user | input | 1 | Access made in user mode |
| lk_store | input | 1 | Access is a store |
| lk_paddr | output | 32 | Physical address |
| lk_uncached | output | 1 | Access must bypass the caches |
| lk_miss | output | 1 | No matching valid entry |
| lk_mod_fault | output | 1 | Store to a page that is not writable |
| lk_addr_fault | output | 1 | User access to the kernel half |
| wr_op | input | 2 | Maintenance opcode: 00 none, 01 write, 10 clear one, 11 clear all |
| wr_idx | input | 6 | Entry index for write or clear-one |
| wr_vpn | input | 20 | Virtual page number to write |
| wr_asid | input | 6 | Identifier to write |
| wr_pfn | input | 20 | Physical page number to write |
| wr_valid | input | 1 | Valid bit to write |
| wr_dirty | input | 1 | Write-enable bit to write |
| wr_readonly | input | 1 | Read-only permission bit to write |
| wr_nocache | input | 1 | Uncached attribute to write |

## Verification
Software maintenance and a lookup can fall in the same cycle, and both may touch the same entry. The bench provokes this by issuing a write to an empty slot together with a lookup of the page being written. It judges the result by requiring a miss in that cycle and a hit with the new frame in the next. Clear-one and clear-all are judged the same way through the lookups that follow them. Priority among duplicate matches and the choice between exception types for the same address in the two privilege modes are also covered.

// File: rtl/tlb_pkg.sv
// Package: shared widths, entry layout and encodings for the translation buffer.
// Assumes a 32-bit virtual address split into a page number and a 12-bit offset.
package tlb_pkg;
    localparam int VA_W      = 32;
    localparam int OFF_W     = 12;
    localparam int VPN_W     = VA_W - OFF_W;
    localparam int PFN_W     = 20;
    localparam int ASID_W    = 6;
    localparam int SEG_W     = 3;

    // One translation slot
    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        logic [ASID_W-1:0] asid;
        logic [PFN_W-1:0]  pfn;
        logic              dirty;     // write enable
        logic              readonly;  // access permission
        logic              nocache;   // cacheability attribute
    } tlb_entry_t;

    // Maintenance opcodes
    typedef enum logic [1:0] {
        OP_NONE    = 2'b00,
        OP_WRITE   = 2'b01,
        OP_INV_ONE = 2'b10,
        OP_INV_ALL = 2'b11
    } wr_op_e;

    // Segment classes from address bits 31:29
    typedef enum logic [1:0] {
        SEG_USER,
        SEG_KPHYS_C,
        SEG_KPHYS_U,
        SEG_KVIRT
    } seg_e;
endpackage

// File: rtl/tlb_seg_decode.sv
// Module: classifies an access by its top address bits and privilege.
// Assumes the segment field sits at the top of the address; purely combinational.
module tlb_seg_decode
    import tlb_pkg::*;
(
    input  logic [SEG_W-1:0] seg_bits,
    input  logic             user,
    output seg_e             seg,
    output logic             mapped,
    output logic             addr_err
);
    // Map the three-bit field onto a segment class
    always_comb begin
        unique casez (seg_bits)
            3'b0??:  seg = SEG_USER;
            3'b100:  seg = SEG_KPHYS_C;
            3'b101:  seg = SEG_KPHYS_U;
            default: seg = SEG_KVIRT;
        endcase
    end

    // Translated segments consult the entries; user code may not leave the low half
    always_comb begin
        mapped   = (seg == SEG_USER) || (seg == SEG_KVIRT);
        addr_err = user && seg_bits[SEG_W-1];
    end
endmodule

// File: rtl/tlb_entry_store.sv
// Module: register file of translation entries with a one-port maintenance interface.
// Assumes at most one maintenance operation per cycle; results are visible next cycle.
module tlb_entry_store
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wr_op_e           wr_op,
    input  logic [IDX_W-1:0] wr_idx,
    input  tlb_entry_t       wr_entry,
    output tlb_entry_t       ents [ENTRIES]
);
    logic [ENTRIES-1:0] vbits;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        logic sel;
        assign sel      = (wr_idx == IDX_W'(i));
        assign vbits[i] = ents[i].valid;

        // Per-slot update: reset, write, clear-one or clear-all
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ents[i] <= '0;
            end else begin
                unique case (wr_op)
                    OP_WRITE:   if (sel) ents[i] <= wr_entry;
                    OP_INV_ONE: if (sel) ents[i].valid <= 1'b0;
                    OP_INV_ALL: ents[i].valid <= 1'b0;
                    default:    ;
                endcase
            end
        end
    end

    // R9: a written slot holds exactly the written value one cycle later
    a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_op == OP_WRITE) |=> (ents[$past(wr_idx)] == $past(wr_entry)));

    // R10: the indexed slot is invalid after a clear-one
    a_r10_clear_one: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_op == OP_INV_ONE) |=> !vbits[$past(wr_idx)]);

    // R11: no slot stays valid after a clear-all
    a_r11_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_op == OP_INV_ALL) |=> (vbits == '0));

    // R11: a no-op leaves the valid bits unchanged
    a_r11_nop_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_op == OP_NONE) |=> $stable(vbits));
endmodule

// File: rtl/tlb_match.sv
// Module: compares a page number and identifier against all entries in parallel
// and selects the lowest-numbered match. Combinational; clock used only by checks.
module tlb_match
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  tlb_entry_t        ents [ENTRIES],
    input  logic [VPN_W-1:0]  vpn,
    input  logic [ASID_W-1:0] asid,
    output logic              hit,
    output tlb_entry_t        hit_ent
);
    logic [ENTRIES-1:0] match;
    logic [ENTRIES-1:0] sel_oh;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign match[i] = ents[i].valid && (ents[i].vpn == vpn) && (ents[i].asid == asid);
    end

    // Priority select: scan downward so the lowest index is applied last
    always_comb begin
        sel_oh  = '0;
        hit     = 1'b0;
        hit_ent = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) begin
                sel_oh    = '0;
                sel_oh[i] = 1'b1;
                hit       = 1'b1;
                hit_ent   = ents[i];
            end
        end
    end

    // R8: one selected slot, it matches, and no lower slot matches
    a_r8_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_oh) && ((sel_oh & ~match) == '0) && (((sel_oh - 1'b1) & match & {ENTRIES{|sel_oh}}) == '0));

    // R2: a hit is reported exactly when some slot matches
    a_r2_hit_any: assert property (@(posedge clk) disable iff (!rst_n)
        hit == ($countones(match) != 0));
endmodule

// File: rtl/tlb_xlate.sv
// Module: top of the translation buffer. Decodes the segment, looks up translated
// addresses, and produces a physical address or a single exception in the same cycle.
// Assumes misses are refilled by software through the maintenance port.
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_user,
    input  logic              lk_store,
    output logic [VA_W-1:0]   lk_paddr,
    output logic              lk_uncached,
    output logic              lk_miss,
    output logic              lk_mod_fault,
    output logic              lk_addr_fault,
    input  logic [1:0]        wr_op,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic              wr_valid,
    input  logic              wr_dirty,
    input  logic              wr_readonly,
    input  logic              wr_nocache
);
    seg_e       seg;
    logic       mapped;
    logic       addr_err;
    logic       hit;
    tlb_entry_t hit_ent;
    tlb_entry_t wr_entry;
    tlb_entry_t ents [ENTRIES];

    // Pack the maintenance fields into one slot image
    always_comb begin
        wr_entry.valid    = wr_valid;
        wr_entry.vpn      = wr_vpn;
        wr_entry.asid     = wr_asid;
        wr_entry.pfn      = wr_pfn;
        wr_entry.dirty    = wr_dirty;
        wr_entry.readonly = wr_readonly;
        wr_entry.nocache  = wr_nocache;
    end

    tlb_seg_decode u_seg (
        .seg_bits (lk_vaddr[VA_W-1 -: SEG_W]),
        .user     (lk_user),
        .seg      (seg),
        .mapped   (mapped),
        .addr_err (addr_err)
    );

    tlb_entry_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_op    (wr_op_e'(wr_op)),
        .wr_idx   (wr_idx),
        .wr_entry (wr_entry),
        .ents     (ents)
    );

    tlb_match #(.ENTRIES(ENTRIES)) u_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .ents    (ents),
        .vpn     (lk_vaddr[VA_W-1:OFF_W]),
        .asid    (lk_asid),
        .hit     (hit),
        .hit_ent (hit_ent)
    );

    // Resolve the access: address error, bypass, miss, modify fault, or translation
    always_comb begin
        lk_paddr      = '0;
        lk_uncached   = 1'b0;
        lk_miss       = 1'b0;
        lk_mod_fault  = 1'b0;
        lk_addr_fault = 1'b0;
        if (lk_req) begin
            if (addr_err) begin
                lk_addr_fault = 1'b1;
            end else if (!mapped) begin
                lk_paddr    = {{SEG_W{1'b0}}, lk_vaddr[VA_W-SEG_W-1:0]};
                lk_uncached = (seg == SEG_KPHYS_U);
            end else if (!hit) begin
                lk_miss = 1'b1;
            end else if (lk_store && (!hit_ent.dirty || hit_ent.readonly)) begin
                lk_mod_fault = 1'b1;
            end else begin
                lk_paddr    = VA_W'({hit_ent.pfn, lk_vaddr[OFF_W-1:0]});
                lk_uncached = hit_ent.nocache;
            end
        end
    end

    // R12: never more than one exception
    a_r12_one_exc: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({lk_miss, lk_mod_fault, lk_addr_fault}) <= 1);

    // R12: idle lookups raise nothing and drive no address
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |-> !(lk_miss || lk_mod_fault || lk_addr_fault) && (lk_paddr == '0));

    // R6: user access to the upper half is an address error
    a_r6_user_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && lk_user && lk_vaddr[VA_W-1]) |-> lk_addr_fault);

    // R4: bypass segments never miss and clear the segment bits
    a_r4_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && !lk_user && (lk_vaddr[VA_W-1 -: 2] == 2'b10))
        |-> !lk_miss && !lk_mod_fault && (lk_paddr[VA_W-1 -: SEG_W] == '0)
            && (lk_paddr[VA_W-SEG_W-1:0] == lk_vaddr[VA_W-SEG_W-1:0]));
endmodule

// File: tb/tlb_xlate_tb.sv
`timescale 1ns/1ps
module tlb_xlate_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [5:0]  lk_asid = '0;
    logic        lk_user = 1'b0;
    logic        lk_store = 1'b0;
    logic [31:0] lk_paddr;
    logic        lk_uncached, lk_miss, lk_mod_fault, lk_addr_fault;
    logic [1:0]  wr_op = 2'b00;
    logic [5:0]  wr_idx = '0;
    logic [19:0] wr_vpn = '0;
    logic [5:0]  wr_asid = '0;
    logic [19:0] wr_pfn = '0;
    logic        wr_valid = 1'b0, wr_dirty = 1'b0, wr_readonly = 1'b0, wr_nocache = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Exception codes used by the bench: 0 none, 1 miss, 2 modify, 3 address
    typedef struct packed {
        logic [31:0] va;
        logic [5:0]  asid;
        logic        user;
        logic        store;
        logic [31:0] pa;
        logic        unc;
        logic [1:0]  exc;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{32'h0001_0123, 6'd5, 1'b1, 1'b0, 32'h0ABC_D123, 1'b0, 2'd0, 4'd2},  // R2 plain hit
        '{32'h0001_0123, 6'd6, 1'b1, 1'b0, 32'h0666_6123, 1'b0, 2'd0, 4'd3},  // R3 other id, own entry
        '{32'h0001_0123, 6'd7, 1'b1, 1'b0, 32'h0000_0000, 1'b0, 2'd1, 4'd3},  // R3 id mismatch misses
        '{32'h0002_0FFF, 6'd5, 1'b1, 1'b0, 32'h0111_1FFF, 1'b1, 2'd0, 4'd2},  // R2 uncached entry
        '{32'h0002_0000, 6'd5, 1'b1, 1'b1, 32'h0000_0000, 1'b0, 2'd2, 4'd7},  // R7 not writable
        '{32'h0003_0004, 6'd5, 1'b1, 1'b1, 32'h0000_0000, 1'b0, 2'd2, 4'd7},  // R7 read-only
        '{32'h0003_0004, 6'd5, 1'b1, 1'b0, 32'h0222_2004, 1'b0, 2'd0, 4'd7},  // R7 load still fine
        '{32'h0004_0010, 6'd5, 1'b1, 1'b0, 32'h0555_5010, 1'b0, 2'd0, 4'd8},  // R8 duplicate, slot 4 wins
        '{32'h8000_1234, 6'd5, 1'b0, 1'b0, 32'h0000_1234, 1'b0, 2'd0, 4'd4},  // R4 cached bypass
        '{32'hA000_1234, 6'd5, 1'b0, 1'b0, 32'h0000_1234, 1'b1, 2'd0, 4'd4},  // R4 uncached bypass
        '{32'hBFFF_FFFF, 6'd5, 1'b0, 1'b1, 32'h1FFF_FFFF, 1'b1, 2'd0, 4'd4},  // R4 top of segment, store
        '{32'hC000_0ABC, 6'd7, 1'b0, 1'b0, 32'h0333_3ABC, 1'b0, 2'd0, 4'd5},  // R5 kernel virtual hit
        '{32'hC000_0ABC, 6'd7, 1'b1, 1'b0, 32'h0000_0000, 1'b0, 2'd3, 4'd6},  // R6 same address, user
        '{32'h8000_0000, 6'd5, 1'b1, 1'b0, 32'h0000_0000, 1'b0, 2'd3, 4'd6},  // R6 user into bypass
        '{32'h0001_0000, 6'd5, 1'b1, 1'b1, 32'h0ABC_D000, 1'b0, 2'd0, 4'd7},  // R7 writable store ok
        '{32'h7FFF_F000, 6'd5, 1'b1, 1'b0, 32'h0000_0000, 1'b0, 2'd1, 4'd2},  // R2 unknown page misses
        '{32'hE000_0000, 6'd7, 1'b0, 1'b0, 32'h0000_0000, 1'b0, 2'd1, 4'd5}   // R5 kernel virtual miss
    };

    tlb_xlate u_dut (
        .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr), .lk_asid(lk_asid),
        .lk_user(lk_user), .lk_store(lk_store), .lk_paddr(lk_paddr), .lk_uncached(lk_uncached),
        .lk_miss(lk_miss), .lk_mod_fault(lk_mod_fault), .lk_addr_fault(lk_addr_fault),
        .wr_op(wr_op), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_asid(wr_asid), .wr_pfn(wr_pfn),
        .wr_valid(wr_valid), .wr_dirty(wr_dirty), .wr_readonly(wr_readonly), .wr_nocache(wr_nocache)
    );

    always #2.5 clk = ~clk;

    // Compare the whole result against an expectation
    task automatic expect_out(input string tag, input logic [31:0] pa, input logic unc, input logic [1:0] exc);
        logic [2:0] exp_x;
        logic [2:0] got_x;
        exp_x = (exc == 2'd1) ? 3'b100 : (exc == 2'd2) ? 3'b010 : (exc == 2'd3) ? 3'b001 : 3'b000;
        got_x = {lk_miss, lk_mod_fault, lk_addr_fault};
        checks++;
        if (lk_paddr !== pa || lk_uncached !== unc || got_x !== exp_x) begin
            errors++;
            $display("FAIL %s: got pa=%h unc=%b miss/mod/addr=%b, expected pa=%h unc=%b miss/mod/addr=%b",
                     tag, lk_paddr, lk_uncached, got_x, pa, unc, exp_x);
        end
    endtask

    // Drive a lookup after the falling edge, then let the combinational result settle
    task automatic lookup(input logic [31:0] va, input logic [5:0] asid, input logic user, input logic st);
        @(negedge clk);
        lk_req = 1'b1; lk_vaddr = va; lk_asid = asid; lk_user = user; lk_store = st;
        #1;
    endtask

    // One maintenance operation held for exactly one rising edge
    task automatic maint(input logic [1:0] op, input int idx, input logic [19:0] vpn, input logic [5:0] asid,
                         input logic [19:0] pfn, input logic d, input logic ro, input logic nc);
        @(negedge clk);
        wr_op = op; wr_idx = 6'(idx); wr_vpn = vpn; wr_asid = asid; wr_pfn = pfn;
        wr_valid = 1'b1; wr_dirty = d; wr_readonly = ro; wr_nocache = nc;
        @(negedge clk);
        wr_op = 2'b00;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got no finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: nothing valid after reset
        lookup(32'h0001_0000, 6'd5, 1'b1, 1'b0);
        expect_out("R1 reset user miss", 32'h0, 1'b0, 2'd1);
        lookup(32'hC000_0000, 6'd0, 1'b0, 1'b0);
        expect_out("R1 reset kernel virtual miss", 32'h0, 1'b0, 2'd1);

        // R12: idle port is quiet
        @(negedge clk);
        lk_req = 1'b0; lk_vaddr = 32'h0001_0000; lk_user = 1'b1;
        #1;
        expect_out("R12 idle", 32'h0, 1'b0, 2'd0);

        // Fill slots used by the vector table
        maint(2'b01, 0,  20'h00010, 6'd5, 20'h0ABCD, 1'b1, 1'b0, 1'b0);
        maint(2'b01, 1,  20'h00020, 6'd5, 20'h01111, 1'b0, 1'b0, 1'b1);
        maint(2'b01, 2,  20'h00030, 6'd5, 20'h02222, 1'b1, 1'b1, 1'b0);
        maint(2'b01, 3,  20'hC0000, 6'd7, 20'h03333, 1'b1, 1'b0, 1'b0);
        maint(2'b01, 9,  20'h00040, 6'd5, 20'h04444, 1'b1, 1'b0, 1'b0);
        maint(2'b01, 4,  20'h00040, 6'd5, 20'h05555, 1'b1, 1'b0, 1'b0);
        maint(2'b01, 10, 20'h00010, 6'd6, 20'h06666, 1'b1, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            lookup(VECS[i].va, VECS[i].asid, VECS[i].user, VECS[i].store);
            expect_out($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].pa, VECS[i].unc, VECS[i].exc);
        end

        // R9: a write and a lookup of the same page in one cycle
        @(negedge clk);
        wr_op = 2'b01; wr_idx = 6'd20; wr_vpn = 20'h00050; wr_asid = 6'd5; wr_pfn = 20'h07777;
        wr_valid = 1'b1; wr_dirty = 1'b1; wr_readonly = 1'b0; wr_nocache = 1'b0;
        lk_req = 1'b1; lk_vaddr = 32'h0005_0008; lk_asid = 6'd5; lk_user = 1'b1; lk_store = 1'b0;
        #1;
        expect_out("R9 same cycle sees old", 32'h0, 1'b0, 2'd1);
        @(negedge clk);
        wr_op = 2'b00;
        #1;
        expect_out("R9 next cycle sees new", 32'h0777_7008, 1'b0, 2'd0);

        // R11: opcode 00 with a live index changes nothing
        maint(2'b00, 0, 20'h0, 6'd0, 20'h0, 1'b0, 1'b0, 1'b0);
        lookup(32'h0001_0123, 6'd5, 1'b1, 1'b0);
        expect_out("R11 no-op keeps slot 0", 32'h0ABC_D123, 1'b0, 2'd0);

        // R10: clear slot 0 only
        maint(2'b10, 0, 20'h0, 6'd0, 20'h0, 1'b0, 1'b0, 1'b0);
        lookup(32'h0001_0123, 6'd5, 1'b1, 1'b0);
        expect_out("R10 cleared slot misses", 32'h0, 1'b0, 2'd1);
        lookup(32'h0001_0123, 6'd6, 1'b1, 1'b0);
        expect_out("R10 neighbour kept", 32'h0666_6123, 1'b0, 2'd0);

        // R8: clearing the winner exposes the higher duplicate
        maint(2'b10, 4, 20'h0, 6'd0, 20'h0, 1'b0, 1'b0, 1'b0);
        lookup(32'h0004_0010, 6'd5, 1'b1, 1'b0);
        expect_out("R8 next duplicate", 32'h0444_4010, 1'b0, 2'd0);

        // R11: clear everything in one operation
        maint(2'b11, 0, 20'h0, 6'd0, 20'h0, 1'b0, 1'b0, 1'b0);
        lookup(32'h0004_0010, 6'd5, 1'b1, 1'b0);
        expect_out("R11 all cleared user", 32'h0, 1'b0, 2'd1);
        lookup(32'hC000_0ABC, 6'd7, 1'b0, 1'b0);
        expect_out("R11 all cleared kernel", 32'h0, 1'b0, 2'd1);
        lookup(32'hA000_0010, 6'd7, 1'b0, 1'b0);
        expect_out("R4 bypass after clear", 32'h0000_0010, 1'b1, 2'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule